// File: doc/BRIEF.md
# 64-bit Event Timer with Register Bus

This block is a free-running 64-bit up-counter with a programmable compare value, reached through a plain 32-bit register bus. Both the counter and the compare value are split into a low word and a high word. A two-bit mode field picks between stopped, single-shot and repeating operation. A separate global control register keeps the counting logic cleared and frozen until software writes both of its release bits.

When the counter reaches the compare value, the block records a sticky event flag. In repeating mode the counter restarts from zero. In single-shot mode the hardware stops itself. The interrupt line is the event flag gated by an enable bit. Software typically clears the counter, loads a compare value, selects a mode and then services the interrupt, clearing the flag by writing a one to it.

Every register access finishes in the cycle it is presented. Read data is combinational from the address. Writes take effect at the next clock edge.

Top module: `evt_timer64`

## Requirements
- R1: After reset every mapped register reads zero and `irq` is low.
- R2: While running, the 64-bit counter {high word at 0x14, low word at 0x10} rises by exactly one per clock, carrying from the low word into the high word.
- R3: Unless bits 1:0 of the global control register (0x24) are both 1, the counter is forced to zero, counter writes are ignored, and no event is raised.
- R4: Each of the four 32-bit words (counter low 0x10, counter high 0x14, compare low 0x18, compare high 0x1C) can be written and read back. The compare value is {0x1C, 0x18}.
- R5: The mode field is bits 7:6 at 0x20 and reads back as written. Value 00 and the unused value 11 both leave the counter holding its value.
- R6: In repeating mode (10), the cycle after the counter equals the compare value, the counter is zero. The sequence therefore repeats every compare+1 cycles, and each match raises an event.
- R7: In single-shot mode (01), a match clears the mode field to 00 by hardware, the counter stays at the compare value, and one event is raised.
- R8: An event sets bit 1 of 0x44. The bit stays set until software writes 1 to it. A match in the same cycle as the clear leaves it set.
- R9: `irq` is high exactly when bit 1 (event flag) and bit 0 (interrupt enable) of 0x44 are both 1.
- R10: Reads of unmapped offsets return zero, and writes to them change no register. Read data is zero whenever no read is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter advances on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, same cycle |
| irq | output | 1 | Interrupt request, level |

## Verification
A wrong count, a missed carry or a wrong wrap shows up on the counter words at the next read, one cycle after the faulty edge. For a mode or event-flag fault, the first place it appears is `irq`, one cycle after the match that should or should not have happened. The bench therefore compares read data and `irq` against a behavioural model on every clock. This lets a single bad cycle surface at once instead of at the end of a long count.

// File: rtl/evt_timer64_pkg.sv
package evt_timer64_pkg;

    localparam logic [7:0] OFS_CNT  = 8'h10;
    localparam logic [7:0] OFS_PRD  = 8'h18;
    localparam logic [7:0] OFS_CTRL = 8'h20;
    localparam logic [7:0] OFS_GCTL = 8'h24;
    localparam logic [7:0] OFS_ICS  = 8'h44;

    localparam int unsigned MODE_LSB    = 6;
    localparam int unsigned ICS_EN_BIT  = 0;
    localparam int unsigned ICS_STS_BIT = 1;

    typedef enum logic [1:0] {
        MODE_OFF      = 2'b00,
        MODE_ONCE     = 2'b01,
        MODE_PERIODIC = 2'b10,
        MODE_RSVD     = 2'b11
    } mode_e;

endpackage

// File: rtl/evt_timer64_dec.sv
module evt_timer64_dec
    import evt_timer64_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned NW     = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NW-1:0]     hit_cnt,
    output logic [NW-1:0]     hit_prd,
    output logic              hit_ctrl,
    output logic              hit_gctl,
    output logic              hit_ics
);

    for (genvar w = 0; w < NW; w++) begin : g_word
        assign hit_cnt[w] = (addr == ADDR_W'(int'(OFS_CNT) + 4 * w));
        assign hit_prd[w] = (addr == ADDR_W'(int'(OFS_PRD) + 4 * w));
    end

    assign hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
    assign hit_gctl = (addr == ADDR_W'(OFS_GCTL));
    assign hit_ics  = (addr == ADDR_W'(OFS_ICS));

endmodule

// File: rtl/evt_timer64_core.sv
module evt_timer64_core
    import evt_timer64_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CNT_W/DATA_W-1:0]  cnt_wr,
    input  logic [CNT_W/DATA_W-1:0]  prd_wr,
    input  logic                     ctrl_wr,
    input  logic                     gctl_wr,
    input  logic                     ics_wr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [CNT_W-1:0]         cnt,
    output logic [CNT_W-1:0]         prd,
    output logic [1:0]               mode,
    output logic [1:0]               gctl,
    output logic                     ien,
    output logic                     sts
);

    localparam int unsigned NW = CNT_W / DATA_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] prd;
        logic [1:0]       mode;
        logic [1:0]       gctl;
        logic             ien;
        logic             sts;
    } state_t;

    state_t st_q, st_d;

    logic released, running, match;

    assign released = (st_q.gctl == 2'b11);
    assign running  = released &&
                      (st_q.mode == MODE_ONCE || st_q.mode == MODE_PERIODIC);
    assign match    = running && (st_q.cnt == st_q.prd);

    always_comb begin
        st_d = st_q;
        // counting and terminal action
        if (running) begin
            if (match) begin
                if (st_q.mode == MODE_PERIODIC) st_d.cnt  = '0;
                else                            st_d.mode = MODE_OFF;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
        // word writes take priority over counting
        for (int w = 0; w < NW; w++) begin
            if (cnt_wr[w] && released) st_d.cnt[w*DATA_W +: DATA_W] = wdata;
            if (prd_wr[w])             st_d.prd[w*DATA_W +: DATA_W] = wdata;
        end
        // held in reset: counter cleared
        if (!released) st_d.cnt = '0;
        if (ctrl_wr)   st_d.mode = wdata[MODE_LSB +: 2];
        if (gctl_wr)   st_d.gctl = wdata[1:0];
        if (ics_wr) begin
            st_d.ien = wdata[ICS_EN_BIT];
            if (wdata[ICS_STS_BIT]) st_d.sts = 1'b0;
        end
        // event set wins over clear
        if (match) st_d.sts = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign prd  = st_q.prd;
    assign mode = st_q.mode;
    assign gctl = st_q.gctl;
    assign ien  = st_q.ien;
    assign sts  = st_q.sts;

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !match && !(|cnt_wr)) |=> (st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));

    assert_held_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!released) |=> (st_q.cnt == '0));

    assert_periodic_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (match && st_q.mode == MODE_PERIODIC && !(|cnt_wr)) |=> (st_q.cnt == '0));

    assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (match && st_q.mode == MODE_ONCE && !ctrl_wr) |=> (st_q.mode == MODE_OFF && $stable(st_q.cnt)));

    assert_sticky_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sts && !(ics_wr && wdata[ICS_STS_BIT])) |=> st_q.sts);

endmodule

// File: rtl/evt_timer64.sv
module evt_timer64
    import evt_timer64_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int unsigned NW = CNT_W / DATA_W;

    logic [NW-1:0]     hit_cnt, hit_prd;
    logic              hit_ctrl, hit_gctl, hit_ics;
    logic              do_wr;
    logic [CNT_W-1:0]  cnt, prd;
    logic [1:0]        mode, gctl;
    logic              ien, sts;
    logic [DATA_W-1:0] cnt_word [NW];
    logic [DATA_W-1:0] prd_word [NW];
    logic [DATA_W-1:0] mux;

    evt_timer64_dec #(.ADDR_W(ADDR_W), .NW(NW)) i_dec (
        .addr     (bus_addr),
        .hit_cnt  (hit_cnt),
        .hit_prd  (hit_prd),
        .hit_ctrl (hit_ctrl),
        .hit_gctl (hit_gctl),
        .hit_ics  (hit_ics)
    );

    assign do_wr = bus_sel && bus_wr;

    evt_timer64_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_wr  (hit_cnt & {NW{do_wr}}),
        .prd_wr  (hit_prd & {NW{do_wr}}),
        .ctrl_wr (hit_ctrl && do_wr),
        .gctl_wr (hit_gctl && do_wr),
        .ics_wr  (hit_ics && do_wr),
        .wdata   (bus_wdata),
        .cnt     (cnt),
        .prd     (prd),
        .mode    (mode),
        .gctl    (gctl),
        .ien     (ien),
        .sts     (sts)
    );

    for (genvar w = 0; w < NW; w++) begin : g_rd
        assign cnt_word[w] = cnt[w*DATA_W +: DATA_W];
        assign prd_word[w] = prd[w*DATA_W +: DATA_W];
    end

    always_comb begin
        mux = '0;
        for (int w = 0; w < NW; w++) begin
            if (hit_cnt[w]) mux = mux | cnt_word[w];
            if (hit_prd[w]) mux = mux | prd_word[w];
        end
        if (hit_ctrl) mux[MODE_LSB +: 2] = mode;
        if (hit_gctl) mux[1:0] = gctl;
        if (hit_ics) begin
            mux[ICS_EN_BIT]  = ien;
            mux[ICS_STS_BIT] = sts;
        end
    end

    assign bus_rdata = (bus_sel && !bus_wr) ? mux : '0;
    assign irq       = sts && ien;

    assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |-> (bus_rdata == '0));

endmodule

// File: tb/test_evt_timer64.sv
module test_evt_timer64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    evt_timer64 i_evt_timer64 (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
    );

    // behavioural reference
    bit [63:0] m_cnt, m_prd;
    bit [1:0]  m_mode, m_g;
    bit        m_en, m_st;

    always @(posedge clk) begin
        bit run, hit;
        if (!rst_n) begin
            m_cnt = 0; m_prd = 0; m_mode = 0; m_g = 0; m_en = 0; m_st = 0;
        end else begin
            run = (m_g == 2'b11) && (m_mode == 2'b01 || m_mode == 2'b10);
            hit = run && (m_cnt == m_prd);
            if (hit && m_mode == 2'b10) m_cnt = 0;
            else if (hit)               m_mode = 2'b00;
            else if (run)               m_cnt = m_cnt + 1;
            if (sel && wr) begin
                case (addr)
                    8'h10: if (m_g == 2'b11) m_cnt[31:0]  = wdata;
                    8'h14: if (m_g == 2'b11) m_cnt[63:32] = wdata;
                    8'h18: m_prd[31:0]  = wdata;
                    8'h1C: m_prd[63:32] = wdata;
                    8'h20: m_mode = wdata[7:6];
                    8'h44: begin m_en = wdata[0]; if (wdata[1]) m_st = 0; end
                    default: ;
                endcase
            end
            if (m_g != 2'b11) m_cnt = 0;
            if (sel && wr && addr == 8'h24) m_g = wdata[1:0];
            if (hit) m_st = 1;
        end
    end

    function automatic bit [31:0] m_rd(bit [7:0] a);
        if (!(sel && !wr)) return 0;
        case (a)
            8'h10: return m_cnt[31:0];
            8'h14: return m_cnt[63:32];
            8'h18: return m_prd[31:0];
            8'h1C: return m_prd[63:32];
            8'h20: return {24'h0, m_mode, 6'h0};
            8'h24: return {30'h0, m_g};
            8'h44: return {30'h0, m_st, m_en};
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(bit [7:0] a);
        case (a)
            8'h10, 8'h14: return "R2";
            8'h18, 8'h1C: return "R4";
            8'h20: return "R5";
            8'h24: return "R3";
            8'h44: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (started && rst_n && !done) begin
            chk("R9", irq, m_st & m_en);
            chk(tag_of(addr), rdata, m_rd(addr));
        end
    end

    task automatic wr_reg(bit [7:0] a, bit [31:0] d);
        @(posedge clk); #1;
        sel = 1; wr = 1; addr = a; wdata = d;
    endtask

    task automatic chk_rd(bit [7:0] a, bit [31:0] exp, string req);
        @(posedge clk); #1;
        sel = 1; wr = 0; addr = a;
        @(negedge clk);
        chk(req, rdata, exp);
    endtask

    task automatic idle(int n);
        @(posedge clk); #1;
        sel = 0; wr = 0;
        repeat (n - 1) @(posedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion earlier", 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        bit [31:0] prev;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        started = 1;

        // R1: reset values
        chk("R1", irq, 0);
        chk_rd(8'h10, 0, "R1"); chk_rd(8'h14, 0, "R1"); chk_rd(8'h18, 0, "R1");
        chk_rd(8'h1C, 0, "R1"); chk_rd(8'h20, 0, "R1"); chk_rd(8'h24, 0, "R1");
        chk_rd(8'h44, 0, "R1");

        // R3: counter writes ignored while held
        wr_reg(8'h24, 0); wr_reg(8'h10, 32'h55);
        chk_rd(8'h10, 0, "R3");

        // R4: word access after release
        wr_reg(8'h24, 3); wr_reg(8'h10, 5); wr_reg(8'h14, 0);
        chk_rd(8'h10, 5, "R4");
        wr_reg(8'h1C, 32'hA5); chk_rd(8'h1C, 32'hA5, "R4");
        wr_reg(8'h1C, 0);

        // R5: stopped and reserved modes hold the count
        idle(5); chk_rd(8'h10, 5, "R5");
        wr_reg(8'h20, 32'hC0); idle(5);
        chk_rd(8'h10, 5, "R5"); chk_rd(8'h20, 32'hC0, "R5");

        // R6: repeating with compare 3
        wr_reg(8'h20, 0); wr_reg(8'h18, 3); wr_reg(8'h10, 0);
        wr_reg(8'h44, 1); wr_reg(8'h20, 32'h80);
        idle(3);
        @(posedge clk); #1; sel = 1; wr = 0; addr = 8'h10;
        @(negedge clk); prev = rdata;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            chk("R6", rdata, (prev + 1) % 4);
            prev = rdata;
        end
        chk_rd(8'h44, 3, "R8");

        // R8: write-one clear
        wr_reg(8'h20, 0); wr_reg(8'h44, 3);
        chk_rd(8'h44, 1, "R8");
        chk("R9", irq, 0);

        // R7: single shot across the word boundary
        wr_reg(8'h10, 32'hFFFF_FFFE); wr_reg(8'h14, 0);
        wr_reg(8'h18, 1); wr_reg(8'h1C, 1); wr_reg(8'h20, 32'h40);
        idle(8);
        chk_rd(8'h20, 0, "R7");
        chk_rd(8'h10, 1, "R7");
        chk_rd(8'h14, 1, "R2");
        chk_rd(8'h44, 3, "R8");
        chk("R9", irq, 1);
        idle(5); chk_rd(8'h10, 1, "R7");

        // R9: enable masks the line
        wr_reg(8'h44, 0); chk_rd(8'h44, 2, "R9");
        chk("R9", irq, 0);
        wr_reg(8'h44, 1); idle(1);
        @(negedge clk); chk("R9", irq, 1);

        // R10: unmapped offsets
        wr_reg(8'h30, 32'hFFFF_FFFF);
        chk_rd(8'h30, 0, "R10"); chk_rd(8'h44, 3, "R10"); chk_rd(8'h28, 0, "R10");

        // R3: hold while running clears the counter
        wr_reg(8'h20, 32'h80); idle(3);
        wr_reg(8'h24, 1); idle(2);
        chk_rd(8'h10, 0, "R3");
        wr_reg(8'h24, 3); idle(6);
        chk_rd(8'h24, 3, "R3");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule